// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block maintains a singly linked chain of 32-bit capability headers kept in a byte-addressed configuration store. The store is 4 KB and the chain always begins at byte offset 256. The store sits outside the block. The block reaches it through a single read/write word port: one 32-bit access per cycle, with read data returned one cycle after the request. It also drives a second, write-only port that clears bytes in the companion write-enable and write-1-to-clear mask stores. One write on that port clears the selected bytes in both masks at once.

A lookup takes a 16-bit capability ID. It follows the chain and reports the byte offset of the first header carrying that ID, together with the offset of the header that points to it. ID 0 is reserved and is never expected to match, so a lookup for ID 0 runs to the end of the chain and reports the final header as the predecessor.

An insertion takes an ID, a version, a byte offset and a region size. It places a new header at that offset and links it into the chain. It then clears both mask stores over the whole new region, so the region becomes read-only by default. Each operation keeps `busy` high while it runs and ends with a one-cycle `done` pulse that carries the result and an error flag.

Top module: `ecw_walker`

## Requirements
- R1: After reset, busy, done, err, cfg_en, cfg_we and msk_we are low, and res_off and res_prev are zero.
- R2: A header word carries the ID in bits 15:0, the version in bits 19:16 and the next-header byte offset in bits 31:20. A next offset of 0 ends the chain. If the word at offset 256 is all zeros, the chain is empty and a lookup ends with err=0, res_off=0 and res_prev=0.
- R3: A lookup returns in res_off the offset of the first header along the chain whose ID equals find_id. res_prev holds the offset of the header before it, or 0 when the match is the header at 256.
- R4: When no header matches, including a lookup for ID 0, the result is res_off=0 and res_prev holding the offset of the last header in the chain.
- R5: Every offset visited during a walk must be a multiple of 4, no less than 256 and no greater than 4088. A walk that reaches any other offset ends with err=1. Every result with err=1 carries res_off=0 and res_prev=0.
- R6: An insertion at offset 256 rewrites the header there with the new ID and version and keeps its existing next field. The result is res_off=256 and res_prev=0.
- R7: An insertion at any other offset walks to the header whose next field is 0. It rewrites that header's next field to the new offset and keeps the header's ID and version. It then writes the new header with next 0. The result is res_off = new offset and res_prev = old tail offset.
- R8: An insertion is rejected with err=1 and no write to either store when any of these holds: the offset is not a multiple of 4, the offset is below 256, the size is 0, offset plus size exceeds 4096, or the chain is empty and the offset is not 256.
- R9: After the header writes, an accepted insertion issues ceil(size/4) mask writes on consecutive word addresses, starting at offset/4. Bit k of msk_be covers byte k of the word. Exactly the bytes in [offset, offset+size) are enabled.
- R10: busy is high from the cycle after a request is taken until the done pulse, and done is never high while busy. A request that arrives while busy is ignored. When both requests arrive together, the insertion is taken. Results hold their value between done pulses.
- R11: A walk that would advance past 960 visited headers, such as a chain that loops, ends with err=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| find_req | input | 1 | Start a lookup (one-cycle pulse) |
| find_id | input | 16 | Capability ID to look up |
| app_req | input | 1 | Start an insertion (one-cycle pulse) |
| app_id | input | 16 | ID of the new header |
| app_ver | input | 4 | Version of the new header |
| app_off | input | 12 | Byte offset of the new header |
| app_size | input | 13 | Byte size of the new region |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag of the last operation |
| res_off | output | 12 | Matching or inserted offset |
| res_prev | output | 12 | Predecessor offset |
| cfg_en | output | 1 | Store access request |
| cfg_we | output | 1 | Store write (with cfg_en) |
| cfg_addr | output | 10 | Store word address |
| cfg_wdata | output | 32 | Store write data |
| cfg_rdata | input | 32 | Store read data, valid one cycle after cfg_en |
| msk_we | output | 1 | Mask clear strobe |
| msk_addr | output | 10 | Mask word address |
| msk_be | output | 4 | Bytes to clear in both masks |

## Verification
The assertions rely on three assumptions about the environment. The external store returns read data exactly one cycle after an access. Requests are single-cycle pulses. Nothing else changes the store while a walk is running. The stimulus respects all three: it edits the bench store only while the block is idle, and it drives each request for exactly one cycle between clock edges. The only exception is the deliberate request raised during a walk, which exercises the rule that such requests are ignored.

// File: rtl/ecw_pkg.sv
package ecw_pkg;
    localparam int HDR_ID_W  = 16;
    localparam int HDR_VER_W = 4;
    localparam int HDR_NXT_W = 12;

    typedef struct packed {
        logic [HDR_NXT_W-1:0] nxt;
        logic [HDR_VER_W-1:0] ver;
        logic [HDR_ID_W-1:0]  id;
    } hdr_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RD    = 3'd1,
        S_EV    = 3'd2,
        S_WTAIL = 3'd3,
        S_WNEW  = 3'd4,
        S_CLR   = 3'd5
    } state_e;

    typedef enum logic [1:0] {
        M_FIND = 2'd0,
        M_HEAD = 2'd1,
        M_TAIL = 2'd2
    } mode_e;
endpackage

// File: rtl/ecw_ofs_chk.sv
module ecw_ofs_chk #(
    parameter int OFF_W = 12,
    parameter int BASE  = 256,
    parameter int SPACE = 4096
) (
    input  logic [OFF_W-1:0] off_i,
    output logic             ok_o
);
    localparam logic [OFF_W:0] LO = (OFF_W+1)'(BASE);
    localparam logic [OFF_W:0] HI = (OFF_W+1)'(SPACE - 8);

    logic [OFF_W:0] off_x;
    assign off_x = {1'b0, off_i};
    assign ok_o  = (off_i[1:0] == 2'b00) && (off_x >= LO) && (off_x <= HI);
endmodule

// File: rtl/ecw_req_chk.sv
module ecw_req_chk #(
    parameter int OFF_W  = 12,
    parameter int SIZE_W = 13,
    parameter int BASE   = 256,
    parameter int SPACE  = 4096
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              ok_o
);
    localparam int EW = SIZE_W + 1;
    localparam logic [EW-1:0] LO  = EW'(BASE);
    localparam logic [EW-1:0] TOP = EW'(SPACE);

    logic [EW-1:0] off_x;
    logic [EW-1:0] end_x;

    assign off_x = EW'(off_i);
    assign end_x = off_x + EW'(size_i);
    assign ok_o  = (off_i[1:0] == 2'b00) && (off_x >= LO) &&
                   (size_i != '0) && (end_x <= TOP);
endmodule

// File: rtl/ecw_be_gen.sv
module ecw_be_gen #(
    parameter int WA_W   = 10,
    parameter int SIZE_W = 13
) (
    input  logic [WA_W-1:0]   idx_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [3:0]        be_o,
    output logic              last_o
);
    localparam int XW = SIZE_W + 2;

    logic [XW-1:0] byte0;
    logic [XW-1:0] words;

    assign byte0  = XW'({idx_i, 2'b00});
    assign words  = (XW'(size_i) + XW'(3)) >> 2;
    assign last_o = (XW'(idx_i) + XW'(1)) == words;

    for (genvar b = 0; b < 4; b++) begin : g_byte
        assign be_o[b] = (byte0 + XW'(b)) < XW'(size_i);
    end
endmodule

// File: rtl/ecw_walker.sv
module ecw_walker #(
    parameter int CFG_BYTES = 4096,
    parameter int EXT_BASE  = 256,
    localparam int OFF_W    = $clog2(CFG_BYTES),
    localparam int WA_W     = OFF_W - 2,
    localparam int SIZE_W   = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              find_req,
    input  logic [15:0]       find_id,
    input  logic              app_req,
    input  logic [15:0]       app_id,
    input  logic [3:0]        app_ver,
    input  logic [OFF_W-1:0]  app_off,
    input  logic [SIZE_W-1:0] app_size,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [OFF_W-1:0]  res_off,
    output logic [OFF_W-1:0]  res_prev,
    output logic              cfg_en,
    output logic              cfg_we,
    output logic [WA_W-1:0]   cfg_addr,
    output logic [31:0]       cfg_wdata,
    input  logic [31:0]       cfg_rdata,
    output logic              msk_we,
    output logic [WA_W-1:0]   msk_addr,
    output logic [3:0]        msk_be
);
    import ecw_pkg::*;

    localparam int MAX_HOPS = (CFG_BYTES - EXT_BASE) / 4;
    localparam int HOP_W    = $clog2(MAX_HOPS + 1);
    localparam logic [OFF_W-1:0] BASE_OFF = OFF_W'(EXT_BASE);

    typedef struct packed {
        state_e                 st;
        mode_e                  mode;
        logic [OFF_W-1:0]       cur;
        logic [OFF_W-1:0]       prev;
        logic [HOP_W-1:0]       hops;
        logic                   first;
        logic [HDR_VER_W-1:0]   tail_ver;
        logic [HDR_ID_W-1:0]    tail_id;
        logic [HDR_NXT_W-1:0]   new_nxt;
        logic [HDR_ID_W-1:0]    id;
        logic [HDR_VER_W-1:0]   ver;
        logic [OFF_W-1:0]       off;
        logic [SIZE_W-1:0]      size;
        logic [WA_W-1:0]        cidx;
        logic                   done;
        logic                   err;
        logic [OFF_W-1:0]       roff;
        logic [OFF_W-1:0]       rprev;
    } regs_t;

    regs_t r_q, r_d;
    hdr_t  hdr;
    logic  cur_ok, req_ok, be_last;
    logic [3:0] be;

    ecw_ofs_chk #(.OFF_W(OFF_W), .BASE(EXT_BASE), .SPACE(CFG_BYTES)) i_ofs_chk (
        .off_i (r_q.cur),
        .ok_o  (cur_ok)
    );

    ecw_req_chk #(.OFF_W(OFF_W), .SIZE_W(SIZE_W), .BASE(EXT_BASE), .SPACE(CFG_BYTES)) i_req_chk (
        .off_i  (app_off),
        .size_i (app_size),
        .ok_o   (req_ok)
    );

    ecw_be_gen #(.WA_W(WA_W), .SIZE_W(SIZE_W)) i_be_gen (
        .idx_i  (r_q.cidx),
        .size_i (r_q.size),
        .be_o   (be),
        .last_o (be_last)
    );

    assign hdr = hdr_t'(cfg_rdata);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        cfg_en    = 1'b0;
        cfg_we    = 1'b0;
        cfg_addr  = r_q.cur[OFF_W-1:2];
        cfg_wdata = '0;
        msk_we    = 1'b0;
        msk_addr  = r_q.off[OFF_W-1:2] + r_q.cidx;
        msk_be    = '0;

        unique case (r_q.st)
            S_IDLE: begin
                if (app_req || find_req) begin
                    r_d.cur   = BASE_OFF;
                    r_d.prev  = '0;
                    r_d.hops  = '0;
                    r_d.first = 1'b1;
                end
                if (app_req) begin
                    r_d.id   = app_id;
                    r_d.ver  = app_ver;
                    r_d.off  = app_off;
                    r_d.size = app_size;
                    if (!req_ok) begin
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                        r_d.roff  = '0;
                        r_d.rprev = '0;
                    end else begin
                        r_d.mode = (app_off == BASE_OFF) ? M_HEAD : M_TAIL;
                        r_d.st   = S_RD;
                    end
                end else if (find_req) begin
                    r_d.id   = find_id;
                    r_d.mode = M_FIND;
                    r_d.st   = S_RD;
                end
            end

            S_RD: begin
                if (!cur_ok) begin
                    r_d.st    = S_IDLE;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b1;
                    r_d.roff  = '0;
                    r_d.rprev = '0;
                end else begin
                    cfg_en = 1'b1;
                    r_d.st = S_EV;
                end
            end

            S_EV: begin
                if (r_q.mode == M_HEAD) begin
                    r_d.new_nxt = hdr.nxt;
                    r_d.st      = S_WNEW;
                end else if (r_q.first && (cfg_rdata == '0)) begin
                    r_d.st    = S_IDLE;
                    r_d.done  = 1'b1;
                    r_d.err   = (r_q.mode == M_TAIL);
                    r_d.roff  = '0;
                    r_d.rprev = '0;
                end else if ((r_q.mode == M_FIND) && (hdr.id == r_q.id)) begin
                    r_d.st    = S_IDLE;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b0;
                    r_d.roff  = r_q.cur;
                    r_d.rprev = r_q.prev;
                end else if (hdr.nxt == '0) begin
                    if (r_q.mode == M_FIND) begin
                        r_d.st    = S_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b0;
                        r_d.roff  = '0;
                        r_d.rprev = r_q.cur;
                    end else begin
                        r_d.prev     = r_q.cur;
                        r_d.tail_ver = hdr.ver;
                        r_d.tail_id  = hdr.id;
                        r_d.new_nxt  = '0;
                        r_d.st       = S_WTAIL;
                    end
                end else if (r_q.hops >= HOP_W'(MAX_HOPS - 1)) begin
                    r_d.st    = S_IDLE;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b1;
                    r_d.roff  = '0;
                    r_d.rprev = '0;
                end else begin
                    r_d.prev  = r_q.cur;
                    r_d.cur   = OFF_W'(hdr.nxt);
                    r_d.first = 1'b0;
                    r_d.hops  = r_q.hops + 1'b1;
                    r_d.st    = S_RD;
                end
            end

            S_WTAIL: begin
                cfg_en    = 1'b1;
                cfg_we    = 1'b1;
                cfg_addr  = r_q.prev[OFF_W-1:2];
                cfg_wdata = {HDR_NXT_W'(r_q.off), r_q.tail_ver, r_q.tail_id};
                r_d.st    = S_WNEW;
            end

            S_WNEW: begin
                cfg_en    = 1'b1;
                cfg_we    = 1'b1;
                cfg_addr  = r_q.off[OFF_W-1:2];
                cfg_wdata = {r_q.new_nxt, r_q.ver, r_q.id};
                r_d.cidx  = '0;
                r_d.st    = S_CLR;
            end

            S_CLR: begin
                msk_we = 1'b1;
                msk_be = be;
                if (be_last) begin
                    r_d.st    = S_IDLE;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b0;
                    r_d.roff  = r_q.off;
                    r_d.rprev = r_q.prev;
                end else begin
                    r_d.cidx = r_q.cidx + 1'b1;
                end
            end

            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != S_IDLE);
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign res_off  = r_q.roff;
    assign res_prev = r_q.rprev;
endmodule

// File: rtl/ecw_walker_chk.sv
module ecw_walker_chk #(
    parameter int EXT_BASE = 256,
    parameter int OFF_W    = 12,
    parameter int WA_W     = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             find_req,
    input logic             app_req,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [OFF_W-1:0] res_off,
    input logic [OFF_W-1:0] res_prev,
    input logic             cfg_en,
    input logic             cfg_we,
    input logic [WA_W-1:0]  cfg_addr,
    input logic             msk_we,
    input logic [WA_W-1:0]  msk_addr,
    input logic [3:0]       msk_be
);
    localparam logic [WA_W-1:0] BASE_W = WA_W'(EXT_BASE / 4);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_start_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(find_req || app_req));

    assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(res_off) || !$stable(res_prev)) |-> done);

    assert_write_in_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we || msk_we) |-> busy);

    assert_we_has_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> cfg_en);

    assert_addr_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (cfg_addr >= BASE_W));

    assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (res_off == '0 && res_prev == '0));

    assert_be_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msk_we |-> (msk_be != 4'b0000));

    assert_mask_contig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_we && $past(msk_we)) |-> (msk_addr == $past(msk_addr) + 1'b1));
endmodule

bind ecw_walker ecw_walker_chk #(.EXT_BASE(EXT_BASE), .OFF_W(OFF_W), .WA_W(WA_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .find_req (find_req),
    .app_req  (app_req),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .res_off  (res_off),
    .res_prev (res_prev),
    .cfg_en   (cfg_en),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .msk_we   (msk_we),
    .msk_addr (msk_addr),
    .msk_be   (msk_be)
);

// File: tb/test_ecw_walker.sv
module test_ecw_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        find_req = 1'b0, app_req = 1'b0;
    logic [15:0] find_id = '0, app_id = '0;
    logic [3:0]  app_ver = '0;
    logic [11:0] app_off = '0;
    logic [12:0] app_size = '0;
    logic        busy, done, err;
    logic [11:0] res_off, res_prev;
    logic        cfg_en, cfg_we, msk_we;
    logic [9:0]  cfg_addr, msk_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = '0;
    logic [3:0]  msk_be;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecw_walker i_ecw_walker (
        .clk(clk), .rst_n(rst_n),
        .find_req(find_req), .find_id(find_id),
        .app_req(app_req), .app_id(app_id), .app_ver(app_ver),
        .app_off(app_off), .app_size(app_size),
        .busy(busy), .done(done), .err(err),
        .res_off(res_off), .res_prev(res_prev),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .msk_we(msk_we), .msk_addr(msk_addr), .msk_be(msk_be)
    );

    logic [31:0] cmem [0:1023];
    logic [3:0]  mmem [0:1023];
    int wr_cnt = 0;

    always @(posedge clk) begin
        if (cfg_en) begin
            if (cfg_we) begin
                cmem[cfg_addr] = cfg_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                cfg_rdata <= cmem[cfg_addr];
            end
        end
        if (msk_we) begin
            mmem[msk_addr] = mmem[msk_addr] & ~msk_be;
            wr_cnt = wr_cnt + 1;
        end
    end

    typedef struct {
        bit          e_err;
        logic [11:0] e_off;
        logic [11:0] e_prev;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_bad = 0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check("R10", "unexpected done", 32'd1, 32'd0);
            end else begin
                e = sb.pop_front();
                check(e.tag, "err", {31'd0, err}, {31'd0, e.e_err});
                check(e.tag, "res_off", {20'd0, res_off}, {20'd0, e.e_off});
                check(e.tag, "res_prev", {20'd0, res_prev}, {20'd0, e.e_prev});
            end
        end
    end

    task automatic wait_done();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_find(logic [15:0] id, bit e_err, logic [11:0] e_off,
                            logic [11:0] e_prev, string tag);
        sb.push_back('{e_err, e_off, e_prev, tag});
        @(negedge clk);
        find_req = 1'b1;
        find_id  = id;
        @(negedge clk);
        find_req = 1'b0;
        wait_done();
    endtask

    task automatic run_app(logic [15:0] id, logic [3:0] ver, logic [11:0] off,
                           logic [12:0] size, bit e_err, logic [11:0] e_off,
                           logic [11:0] e_prev, string tag);
        sb.push_back('{e_err, e_off, e_prev, tag});
        @(negedge clk);
        app_req  = 1'b1;
        app_id   = id;
        app_ver  = ver;
        app_off  = off;
        app_size = size;
        @(negedge clk);
        app_req = 1'b0;
        wait_done();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int w;
        for (int i = 0; i < 1024; i++) begin
            cmem[i] = '0;
            mmem[i] = 4'hF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", {31'd0, busy}, 32'd0);
        check("R1", "done", {31'd0, done}, 32'd0);
        check("R1", "err", {31'd0, err}, 32'd0);
        check("R1", "strobes", {29'd0, cfg_en, cfg_we, msk_we}, 32'd0);
        check("R1", "results", {8'd0, res_off, res_prev}, 32'd0);

        // R2 empty chain
        run_find(16'h0005, 1'b0, 12'h000, 12'h000, "R2");
        // R8 empty chain, insertion away from the start
        run_app(16'h0030, 4'h1, 12'h300, 13'd4, 1'b1, 12'h000, 12'h000, "R8");
        check("R8", "writes on empty", wr_cnt, 32'd0);
        check("R8", "mask untouched", {28'd0, mmem[192]}, 32'hF);

        // R6 first header at the start
        run_app(16'h0001, 4'h1, 12'h100, 13'd8, 1'b0, 12'h100, 12'h000, "R6");
        check("R6", "head word", cmem[64], 32'h0001_0001);
        check("R9", "mask w64", {28'd0, mmem[64]}, 32'h0);
        check("R9", "mask w65", {28'd0, mmem[65]}, 32'h0);
        check("R9", "mask w66", {28'd0, mmem[66]}, 32'hF);

        // R7 tail insertion, partial last word
        run_app(16'h000B, 4'h2, 12'h148, 13'd10, 1'b0, 12'h148, 12'h100, "R7");
        check("R7", "old tail", cmem[64], 32'h1481_0001);
        check("R7", "new hdr", cmem[82], 32'h0002_000B);
        check("R9", "mask w83", {28'd0, mmem[83]}, 32'h0);
        check("R9", "mask w84", {28'd0, mmem[84]}, 32'hC);
        check("R9", "mask w85", {28'd0, mmem[85]}, 32'hF);

        run_app(16'h0010, 4'h1, 12'h200, 13'd4, 1'b0, 12'h200, 12'h148, "R7");
        check("R7", "old tail 2", cmem[82], 32'h2002_000B);
        check("R7", "new hdr 2", cmem[128], 32'h0001_0010);

        // R3 / R4 lookups
        run_find(16'h000B, 1'b0, 12'h148, 12'h100, "R3");
        run_find(16'h0001, 1'b0, 12'h100, 12'h000, "R3");
        run_find(16'h0010, 1'b0, 12'h200, 12'h148, "R3");
        run_find(16'h7777, 1'b0, 12'h000, 12'h200, "R4");
        run_find(16'h0000, 1'b0, 12'h000, 12'h200, "R4");

        // R6 rewrite at the start keeps next
        run_app(16'h0002, 4'h3, 12'h100, 13'd4, 1'b0, 12'h100, 12'h000, "R6");
        check("R6", "head kept next", cmem[64], 32'h1483_0002);
        run_find(16'h0001, 1'b0, 12'h000, 12'h200, "R4");

        // R8 rejected insertions
        w = wr_cnt;
        run_app(16'h0050, 4'h1, 12'h201, 13'd4, 1'b1, 12'h000, 12'h000, "R8");
        run_app(16'h0050, 4'h1, 12'h0FC, 13'd4, 1'b1, 12'h000, 12'h000, "R8");
        run_app(16'h0050, 4'h1, 12'h120, 13'd0, 1'b1, 12'h000, 12'h000, "R8");
        run_app(16'h0050, 4'h1, 12'hFFC, 13'd8, 1'b1, 12'h000, 12'h000, "R8");
        check("R8", "no writes", wr_cnt, w);
        check("R8", "tail intact", cmem[128], 32'h0001_0010);

        // R5 upper bound is accepted
        run_app(16'h0020, 4'h1, 12'hFF8, 13'd8, 1'b0, 12'hFF8, 12'h200, "R5");
        check("R9", "mask top", {24'd0, mmem[1022], mmem[1023]}, 32'h0);
        run_find(16'h0000, 1'b0, 12'h000, 12'hFF8, "R5");

        // R5 corrupted next pointers
        cmem[1022] = 32'h0F01_0020;
        run_find(16'h9999, 1'b1, 12'h000, 12'h000, "R5");
        cmem[1022] = 32'hFFC1_0020;
        run_find(16'h9999, 1'b1, 12'h000, 12'h000, "R5");
        cmem[1022] = 32'h2021_0020;
        run_find(16'h9999, 1'b1, 12'h000, 12'h000, "R5");
        // R11 looping chain
        cmem[1022] = 32'h1481_0020;
        run_find(16'h9999, 1'b1, 12'h000, 12'h000, "R11");
        cmem[1022] = 32'h0001_0020;
        run_find(16'h0020, 1'b0, 12'hFF8, 12'h200, "R3");

        // R10 request during busy is ignored
        w = wr_cnt;
        sb.push_back('{1'b0, 12'h000, 12'hFF8, "R10"});
        @(negedge clk);
        find_req = 1'b1;
        find_id  = 16'h9999;
        @(negedge clk);
        find_req = 1'b0;
        check("R10", "busy", {31'd0, busy}, 32'd1);
        app_req  = 1'b1;
        app_id   = 16'h0040;
        app_ver  = 4'h1;
        app_off  = 12'h300;
        app_size = 13'd4;
        @(negedge clk);
        app_req = 1'b0;
        wait_done();
        repeat (6) @(negedge clk);
        check("R10", "ignored writes", wr_cnt, w);
        check("R10", "ignored hdr", cmem[192], 32'h0);

        // R10 simultaneous requests: insertion wins
        sb.push_back('{1'b1, 12'h000, 12'h000, "R10"});
        @(negedge clk);
        find_req = 1'b1;
        find_id  = 16'h0010;
        app_req  = 1'b1;
        app_off  = 12'h201;
        app_size = 13'd4;
        @(negedge clk);
        find_req = 1'b0;
        app_req  = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);
        check("R10", "idle at end", {31'd0, busy}, 32'd0);

        finish_run();
    end
endmodule